// File: doc/BRIEF.md
# Bi-Endian Load/Store Byte Lane Steering

This block sits on the load/store data path between a 32-bit CPU core and a 32-bit external bus. It puts every byte of a byte, halfword or word access on the correct bus lane. Two independent mode bits set the byte order: one for the CPU and one for the bus. User code can therefore run in either order while memory, I/O and the bus keep one fixed byte placement.

A single lane multiplexer handles both jobs. It picks the sub-word lane from the low address bits, and it applies the extra reversal patterns that are needed when the two orders differ. No separate swap stage is added. Load results are registered and extended to 32 bits. Store data and byte enables are combinational from the request.

The mode bits are registered. A write to them changes only accesses that start after the clock edge that captures the write.

Top module: `endian_lane_steer`

## Requirements
- R1: While `rst` is high, and after it falls until the first load, `ld_valid` is 0 and `ld_data` is 0. Both order bits reset to 0, where 0 means little-endian and 1 means big-endian.
- R2: On a rising edge with `mode_we` = 1, the order bits load `mode_cpu_big` and `mode_bus_big`; without `mode_we` they hold. Consider a load sampled at that same edge, or a store driven in the cycle before it. Either one uses the previous order bits.
- R3: A word load (`ld_size` = 2'b10) returns `bus_rdata` unchanged when the two order bits are equal. When they differ, it returns `bus_rdata` with its four bytes reversed.
- R4: A halfword load (`ld_size` = 2'b01) with offset o = {`ld_addr[1]`,0} reads the lane pair starting at lane o for a little-endian bus, or at lane 2−o for a big-endian bus. The two bytes are swapped when the order bits differ.
- R5: A byte load (`ld_size` = 2'b00) reads lane `ld_addr` for a little-endian bus, or lane 3−`ld_addr` for a big-endian bus, whatever the CPU order.
- R6: Byte and halfword loads fill the upper bits of `ld_data` with zeros when `ld_signed` = 0. When `ld_signed` = 1 they fill them with copies of the top bit of the selected sub-word.
- R7: `ld_data` and `ld_valid` = 1 appear one clock edge after a cycle with `ld_req` = 1. After an edge without `ld_req`, `ld_valid` is 0 and `ld_data` holds its value.
- R8: A word store (`st_size` = 2'b10) drives `bus_be` = 4'b1111. `bus_wdata` equals `st_wdata` when the order bits are equal, and `st_wdata` byte-reversed when they differ.
- R9: A halfword store drives the low halfword of `st_wdata` onto both lane pairs, with its bytes swapped when the orders differ. It sets the two `bus_be` bits of the lane pair chosen as in R4.
- R10: A byte store copies the low byte of `st_wdata` onto all four lanes. It sets the single `bus_be` bit of the lane chosen as in R5.
- R11: With `st_req` = 0, `bus_be` is 4'b0000.
- R12: Size code 2'b11 behaves as a word access. Word accesses ignore both address bits, and halfword accesses ignore address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the two order bits |
| mode_cpu_big | input | 1 | New CPU byte order (1 = big-endian) |
| mode_bus_big | input | 1 | New bus byte order (1 = big-endian) |
| ld_req | input | 1 | Load data is present on the bus this cycle |
| ld_size | input | 2 | Load size: 00 byte, 01 halfword, 10/11 word |
| ld_signed | input | 1 | Sign-extend sub-word load |
| ld_addr | input | 2 | Low address bits of the load |
| bus_rdata | input | 32 | Raw data from the bus lanes |
| ld_valid | output | 1 | Registered load result valid |
| ld_data | output | 32 | Registered, steered and extended load result |
| st_req | input | 1 | Store request this cycle |
| st_size | input | 2 | Store size, same code as `ld_size` |
| st_addr | input | 2 | Low address bits of the store |
| st_wdata | input | 32 | Store data from the core, right-justified |
| bus_wdata | output | 32 | Store data placed on the bus lanes |
| bus_be | output | 4 | Byte enables, bit k for lane k |

## Verification
Store results are combinational. The bench drives them on a falling edge and compares `bus_wdata` and `bus_be` one nanosecond later, in the same cycle. Load results cross one register. The bench drives `ld_req` on a falling edge and compares `ld_data` and `ld_valid` at the next falling edge, after the capturing rising edge. Mode writes are checked on both sides of the edge that captures them: a store and a load issued together with the write must still see the old orders, and the next pair must see the new ones.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;

    typedef struct packed {
        logic cpu_big;
        logic bus_big;
    } order_t;

    typedef struct packed {
        size_e             size;
        logic [OFF_W-1:0]  off;
        logic              sext;
    } ld_access_t;

    // number of lanes an access covers
    function automatic int span(size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return LANES;
        endcase
    endfunction

    // naturally aligned byte offset of the access inside the word
    function automatic int aligned_base(size_e s, logic [OFF_W-1:0] off);
        int n;
        n = span(s);
        return int'(off) - (int'(off) % n);
    endfunction

    // memory byte offset that sits on a lane, given the bus order
    function automatic int mirror(int idx, logic big);
        return big ? (LANES - 1 - idx) : idx;
    endfunction

    // which core byte feeds a bus lane on a store
    function automatic int store_src(int lane, size_e s, order_t o);
        int n;
        int r;
        n = span(s);
        r = mirror(lane, o.bus_big) % n;
        return o.cpu_big ? (n - 1 - r) : r;
    endfunction

    // does a bus lane belong to the addressed sub-word on a store
    function automatic logic store_hit(int lane, size_e s, logic [OFF_W-1:0] off, logic bus_big);
        int n;
        int a;
        n = span(s);
        a = mirror(lane, bus_big);
        return (a - (a % n)) == aligned_base(s, off);
    endfunction

endpackage

// File: rtl/lane_order_reg.sv
module lane_order_reg
    import lane_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  order_t nxt,
    output order_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (we) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lane_load_path.sv
module lane_load_path
    import lane_pkg::*;
#(
    parameter int LW = lane_pkg::LANE_W,
    localparam int DW = LANES * LW
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  ld_access_t  acc,
    input  order_t      ord,
    input  logic [DW-1:0] rdata,
    output logic        valid,
    output logic [DW-1:0] data
);

    int            n;
    int            base;
    int            blane;
    logic          swap;
    logic          fill_bit;
    logic [DW-1:0] picked;

    // one multiplexer: sub-word lane choice plus reversal when orders differ
    always_comb begin
        n        = span(acc.size);
        base     = aligned_base(acc.size, acc.off);
        blane    = ord.bus_big ? (LANES - n - base) : base;
        swap     = ord.cpu_big ^ ord.bus_big;
        picked   = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < n) begin
                picked[j*LW +: LW] = rdata[(blane + (swap ? (n - 1 - j) : j))*LW +: LW];
            end
        end
        fill_bit = acc.sext & picked[n*LW - 1];
        for (int j = 0; j < LANES; j++) begin
            if (j >= n) begin
                picked[j*LW +: LW] = {LW{fill_bit}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= req;
            if (req) begin
                data <= picked;
            end
        end
    end

endmodule

// File: rtl/lane_store_path.sv
module lane_store_path
    import lane_pkg::*;
#(
    parameter int LW = lane_pkg::LANE_W,
    localparam int DW = LANES * LW
) (
    input  logic             req,
    input  size_e            size,
    input  logic [OFF_W-1:0] off,
    input  order_t           ord,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    lane_data,
    output logic [LANES-1:0] lane_be
);

    generate
        for (genvar L = 0; L < LANES; L++) begin : g_lane
            assign lane_data[L*LW +: LW] = wdata[store_src(L, size, ord)*LW +: LW];
            assign lane_be[L]            = req & store_hit(L, size, off, ord.bus_big);
        end
    endgenerate

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
    import lane_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_we,
    input  logic        mode_cpu_big,
    input  logic        mode_bus_big,
    input  logic        ld_req,
    input  logic [1:0]  ld_size,
    input  logic        ld_signed,
    input  logic [1:0]  ld_addr,
    input  logic [31:0] bus_rdata,
    output logic        ld_valid,
    output logic [31:0] ld_data,
    input  logic        st_req,
    input  logic [1:0]  st_size,
    input  logic [1:0]  st_addr,
    input  logic [31:0] st_wdata,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_be
);

    order_t     ord_q;
    order_t     ord_nxt;
    ld_access_t ld_acc;

    assign ord_nxt.cpu_big = mode_cpu_big;
    assign ord_nxt.bus_big = mode_bus_big;

    assign ld_acc.size = size_e'(ld_size);
    assign ld_acc.off  = ld_addr;
    assign ld_acc.sext = ld_signed;

    lane_order_reg u_order (
        .clk (clk),
        .rst (rst),
        .we  (mode_we),
        .nxt (ord_nxt),
        .cur (ord_q)
    );

    lane_load_path #(.LW(LANE_W)) u_load (
        .clk   (clk),
        .rst   (rst),
        .req   (ld_req),
        .acc   (ld_acc),
        .ord   (ord_q),
        .rdata (bus_rdata),
        .valid (ld_valid),
        .data  (ld_data)
    );

    lane_store_path #(.LW(LANE_W)) u_store (
        .req       (st_req),
        .size      (size_e'(st_size)),
        .off       (st_addr),
        .ord       (ord_q),
        .wdata     (st_wdata),
        .lane_data (bus_wdata),
        .lane_be   (bus_be)
    );

endmodule

// File: rtl/endian_lane_steer_chk.sv
module endian_lane_steer_chk
    import lane_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mode_we,
    input logic        mode_cpu_big,
    input logic        mode_bus_big,
    input order_t      ord,
    input logic        ld_req,
    input logic [1:0]  ld_size,
    input logic        ld_signed,
    input logic [31:0] bus_rdata,
    input logic        ld_valid,
    input logic [31:0] ld_data,
    input logic        st_req,
    input logic [1:0]  st_size,
    input logic [31:0] st_wdata,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be
);

    AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(ord)); // R2
    AST_ORDER_LOAD: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (ord.cpu_big == $past(mode_cpu_big) && ord.bus_big == $past(mode_bus_big))); // R2
    AST_WORD_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_size[1] && ord.cpu_big == ord.bus_big) |=> ld_data == $past(bus_rdata)); // R3
    AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_signed && ld_size == 2'b00) |=> ld_data[31:8] == 24'h0); // R6
    AST_LOAD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> ld_valid); // R7
    AST_LOAD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> (!ld_valid && $stable(ld_data))); // R7
    AST_WORD_STORE_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_size[1]) |-> bus_be == 4'b1111); // R8
    AST_WORD_STORE_PASS: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_size[1] && ord.cpu_big == ord.bus_big) |-> bus_wdata == st_wdata); // R8
    AST_HALF_STORE_TWO_LANES: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_size == 2'b01) |-> $countones(bus_be) == 2); // R9
    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_size == 2'b00) |-> $onehot0(bus_be) && bus_be != 4'b0000); // R10
    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !st_req |-> bus_be == 4'b0000); // R11

endmodule

bind endian_lane_steer endian_lane_steer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_we      (mode_we),
    .mode_cpu_big (mode_cpu_big),
    .mode_bus_big (mode_bus_big),
    .ord          (ord_q),
    .ld_req       (ld_req),
    .ld_size      (ld_size),
    .ld_signed    (ld_signed),
    .bus_rdata    (bus_rdata),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data),
    .st_req       (st_req),
    .st_size      (st_size),
    .st_wdata     (st_wdata),
    .bus_wdata    (bus_wdata),
    .bus_be       (bus_be)
);

// File: tb/tb_endian_lane_steer.sv
`timescale 1ns/1ps
module tb_endian_lane_steer;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_we, mode_cpu_big, mode_bus_big;
    logic        ld_req, ld_signed;
    logic [1:0]  ld_size, ld_addr;
    logic [31:0] bus_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        st_req;
    logic [1:0]  st_size, st_addr;
    logic [31:0] st_wdata;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    bit cur_cpu = 0;
    bit cur_bus = 0;

    always #2.5 clk = ~clk;

    endian_lane_steer dut (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_cpu_big(mode_cpu_big), .mode_bus_big(mode_bus_big),
        .ld_req(ld_req), .ld_size(ld_size), .ld_signed(ld_signed), .ld_addr(ld_addr),
        .bus_rdata(bus_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .st_req(st_req), .st_size(st_size), .st_addr(st_addr), .st_wdata(st_wdata),
        .bus_wdata(bus_wdata), .bus_be(bus_be)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic int base_of(logic [1:0] sz, logic [1:0] a);
        int n = nbytes(sz);
        return (n == 4) ? 0 : (n == 2) ? int'(a & 2'b10) : int'(a);
    endfunction

    // memory-address view: core byte j is memory byte base+k, which sits on a lane
    function automatic logic [31:0] exp_load(logic [1:0] sz, logic [1:0] a, bit sg,
                                             bit cpu, bit bus, logic [31:0] rd);
        int n = nbytes(sz);
        int b = base_of(sz, a);
        logic [31:0] r = '0;
        for (int j = 0; j < n; j++) begin
            int m = b + (cpu ? n - 1 - j : j);
            int lane = bus ? 3 - m : m;
            r[8*j +: 8] = rd[8*lane +: 8];
        end
        if (n < 4 && sg && r[8*n-1]) r = r | ~((32'h1 << (8*n)) - 1);
        return r;
    endfunction

    // arithmetic view: right-justified value, reversed inside its size, replicated
    function automatic logic [31:0] exp_store(logic [1:0] sz, bit cpu, bit bus, logic [31:0] wd);
        int n = nbytes(sz);
        logic [31:0] h = wd;
        if (cpu != bus) h = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} >> (8*(4-n));
        if (n == 1) return {4{h[7:0]}};
        if (n == 2) return {2{h[15:0]}};
        return h;
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] a, bit bus);
        int n = nbytes(sz);
        int b = base_of(sz, a);
        if (n == 4) return 4'b1111;
        if (n == 1) return 4'b0001 << (bus ? 3 - b : b);
        return 4'b0011 << (bus ? 2 - b : b);
    endfunction

    function automatic string tag_of(logic [1:0] sz);
        return (sz == 2'b00) ? "R5" : (sz == 2'b01) ? "R4" : (sz == 2'b10) ? "R3" : "R12";
    endfunction

    task automatic set_mode(bit cpu, bit bus);
        @(negedge clk);
        mode_we = 1'b1; mode_cpu_big = cpu; mode_bus_big = bus;
        @(negedge clk);
        mode_we = 1'b0;
        cur_cpu = cpu; cur_bus = bus;
    endtask

    task automatic do_load(logic [1:0] sz, logic [1:0] a, bit sg, logic [31:0] rd);
        logic [31:0] e;
        int n;
        @(negedge clk);
        ld_req = 1'b1; ld_size = sz; ld_addr = a; ld_signed = sg; bus_rdata = rd;
        @(negedge clk);
        ld_req = 1'b0;
        e = exp_load(sz, a, sg, cur_cpu, cur_bus, rd);
        n = nbytes(sz);
        chk("R7 valid", {31'b0, ld_valid}, 32'd1);
        chk(tag_of(sz), ld_data & ((n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1)),
            e & ((n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1)));
        if (n < 4) chk("R6 extension", ld_data, e);
    endtask

    task automatic do_store(logic [1:0] sz, logic [1:0] a, logic [31:0] wd);
        string t;
        @(negedge clk);
        st_req = 1'b1; st_size = sz; st_addr = a; st_wdata = wd;
        #1;
        t = (sz == 2'b00) ? "R10" : (sz == 2'b01) ? "R9" : (sz == 2'b10) ? "R8" : "R12";
        chk(t, bus_wdata, exp_store(sz, cur_cpu, cur_bus, wd));
        chk(t, {28'b0, bus_be}, {28'b0, exp_be(sz, a, cur_bus)});
        st_req = 1'b0;
        #1;
        chk("R11 idle", {28'b0, bus_be}, 32'h0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [3];
        logic [31:0] hold;
        rst = 1'b1; mode_we = 0; mode_cpu_big = 0; mode_bus_big = 0;
        ld_req = 0; ld_size = 0; ld_signed = 0; ld_addr = 0; bus_rdata = 0;
        st_req = 0; st_size = 0; st_addr = 0; st_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", {31'b0, ld_valid}, 32'd0);
        chk("R1 data in reset", ld_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'b0, ld_valid}, 32'd0);
        chk("R1 data after reset", ld_data, 32'd0);
        // reset orders are both little: word load passes through
        do_load(2'b10, 2'b00, 1'b0, 32'hA1B2C3D4);

        // R7: no request -> valid drops, data holds
        hold = ld_data;
        @(negedge clk);
        chk("R7 idle valid", {31'b0, ld_valid}, 32'd0);
        chk("R7 idle hold", ld_data, hold);

        // R2: write and access in the same cycle use the old orders
        @(negedge clk);
        mode_we = 1'b1; mode_cpu_big = 1'b1; mode_bus_big = 1'b0;
        ld_req = 1'b1; ld_size = 2'b10; ld_addr = 0; ld_signed = 0; bus_rdata = 32'h11223344;
        st_req = 1'b1; st_size = 2'b10; st_addr = 0; st_wdata = 32'h55667788;
        #1;
        chk("R2 store old order", bus_wdata, 32'h55667788);
        @(negedge clk);
        mode_we = 1'b0; ld_req = 1'b0; st_req = 1'b0;
        chk("R2 load old order", ld_data, 32'h11223344);
        cur_cpu = 1; cur_bus = 0;
        do_load(2'b10, 2'b00, 1'b0, 32'h11223344);
        chk("R2 load new order", ld_data, 32'h44332211);
        do_store(2'b10, 2'b00, 32'h55667788);

        pats[0] = 32'hF162_9304;
        pats[1] = 32'h17A8_39CA;
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 2; b++) begin
                set_mode(c[0], b[0]);
                for (int s = 0; s < 4; s++) begin
                    for (int a = 0; a < 4; a++) begin
                        pats[2] = $urandom;
                        for (int p = 0; p < 3; p++) begin
                            for (int g = 0; g < 2; g++) begin
                                do_load(s[1:0], a[1:0], g[0], pats[p]);
                            end
                            do_store(s[1:0], a[1:0], pats[p]);
                        end
                    end
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule